// File: doc/BRIEF.md
# Bus Yield Policy

This block sits beside a processor's bus arbitration logic and makes two decisions on every rising edge of the processor clock. The first is whether the processor needs the shared multi-master bus for the cycle it is starting. The second is whether the bus that this agent holds may be handed to another agent. It works from the processor's three-bit status code and from two topology straps. The straps choose one of four bus layouts: shared bus only, shared bus plus a private peripheral bus, shared bus plus a private resident bus, or all three. An address-decoder select line says whether an access targets the shared bus or the resident bus.

Three kinds of event can allow the bus to be given up. The first is the processor halting. The second is a pending request from a lower-priority agent. The third is a higher-priority agent requesting the bus. A second strap lets a lower-priority request be honoured as readily as a higher-priority one. Two lock inputs restrict the result. A bus lock forbids giving up the bus at all. A common-request lock masks only the surrender causes that come from the lower-priority request line. Both results are registered, so each one reflects the inputs present at the previous rising edge. The handshake that actually hands over the bus is handled elsewhere.

Top module: `bus_yield_policy`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `bus_need` and `surrender_ok` at that edge, whatever the other inputs are.
- R2: Status codes are classified as follows: 000, 001 and 010 are I/O commands; 011 is halt; 100, 101 and 110 are memory commands; 111 is idle. I/O and memory commands are active. Halt and idle never raise `bus_need`.
- R3: In shared-only topology (`strap_iob_n`=1, `strap_resb`=0), `bus_need` is 1 for every active status.
- R4: In peripheral topology (`strap_iob_n`=0, `strap_resb`=0), `bus_need` is 1 only for memory commands.
- R5: In resident topology (`strap_iob_n`=1, `strap_resb`=1), `bus_need` is 1 only for an active status with `sys_sel`=1.
- R6: In combined topology (`strap_iob_n`=0, `strap_resb`=1), `bus_need` is 1 only for a memory command with `sys_sel`=1.
- R7: A halt status sets `surrender_ok` in every topology while `lock_n`=1.
- R8: `prio_in_n`=1 (a higher-priority request) sets `surrender_ok` while `lock_n`=1, even when the status needs the bus.
- R9: With `strap_any`=0, `peer_req`=1 sets `surrender_ok` only when the current status does not need the bus in the selected topology.
- R10: With `strap_any`=1, `peer_req`=1 sets `surrender_ok` even when the status needs the bus. Holding `peer_req` high therefore releases the bus after every transfer.
- R11: While `lock_n`=0, `surrender_ok` is 0 whatever the status and request inputs are.
- R12: While `crq_lock_n`=0, `peer_req` has no effect on `surrender_ok`. Halt and higher-priority causes still apply.
- R13: With `peer_req`=0 and `prio_in_n`=0, `surrender_ok` is 0 for every status except halt.
- R14: Both outputs change only at a rising clock edge, one cycle after the inputs they reflect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| status | input | 3 | Processor bus status code |
| strap_iob_n | input | 1 | Peripheral-bus topology strap, active low |
| strap_resb | input | 1 | Resident-bus topology strap, active high |
| strap_any | input | 1 | Treat lower-priority requests as urgent |
| sys_sel | input | 1 | Address decoder: 1 selects the shared bus |
| peer_req | input | 1 | Lower-priority agent requests the bus |
| prio_in_n | input | 1 | Bus priority in; high means a higher-priority request |
| lock_n | input | 1 | Bus lock, active low |
| crq_lock_n | input | 1 | Common-request lock, active low |
| bus_need | output | 1 | Registered: processor needs the shared bus |
| surrender_ok | output | 1 | Registered: held bus may be given up |

## Verification
The properties assume that every input is a clean, settled level at each rising edge of `clk` and that the straps are static within a test phase. They also assume that `rst` is synchronous, so each clocked property can be checked one edge after its cause. The bench changes every input only on the falling edge and changes the straps only between scenarios. It samples the outputs on the falling edge after the capturing rising edge, and it probes once just before an edge to confirm that nothing moves early.

// File: rtl/byp_pkg.sv
package byp_pkg;

   typedef enum logic [1:0] {
      CLS_IO   = 2'd0,
      CLS_HALT = 2'd1,
      CLS_MEM  = 2'd2,
      CLS_IDLE = 2'd3
   } stat_cls_e;

   typedef enum logic [1:0] {
      TOPO_SHARED   = 2'd0,
      TOPO_PERIPH   = 2'd1,
      TOPO_RESIDENT = 2'd2,
      TOPO_COMBINED = 2'd3
   } topo_e;

   // Map strap levels onto a topology; iob_n is active low, resb active high.
   function automatic topo_e straps_to_topo(input logic iob_n, input logic resb);
      topo_e t;
      case ({iob_n, resb})
         2'b10:   t = TOPO_SHARED;
         2'b00:   t = TOPO_PERIPH;
         2'b11:   t = TOPO_RESIDENT;
         default: t = TOPO_COMBINED;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/byp_status_class.sv
module byp_status_class #(
   parameter int unsigned STATUS_W  = 3,
   parameter int unsigned HALT_CODE = 3,
   parameter int unsigned IDLE_CODE = 7
) (
   input  logic [STATUS_W-1:0] status,
   output byp_pkg::stat_cls_e  cls
);
   import byp_pkg::*;

   localparam int unsigned NCODES = 1 << STATUS_W;
   localparam int unsigned MEM_BIT = STATUS_W - 1;

   if (STATUS_W < 2 || STATUS_W > 6) begin : g_bad_width
      $error("byp_status_class: STATUS_W out of range");
   end
   if (HALT_CODE == IDLE_CODE) begin : g_bad_codes
      $error("byp_status_class: halt and idle codes must differ");
   end
   if (HALT_CODE >= NCODES || IDLE_CODE >= NCODES) begin : g_bad_range
      $error("byp_status_class: special code exceeds status width");
   end

   stat_cls_e lut [NCODES];

   for (genvar c = 0; c < NCODES; c++) begin : g_code
      localparam logic [STATUS_W-1:0] CODE = STATUS_W'(c);
      if (c == IDLE_CODE) begin : g_idle
         assign lut[c] = CLS_IDLE;
      end else if (c == HALT_CODE) begin : g_halt
         assign lut[c] = CLS_HALT;
      end else if (CODE[MEM_BIT]) begin : g_mem
         assign lut[c] = CLS_MEM;
      end else begin : g_io
         assign lut[c] = CLS_IO;
      end
   end

   assign cls = lut[status];

endmodule

// File: rtl/byp_need_decode.sv
module byp_need_decode (
   input  byp_pkg::stat_cls_e cls,
   input  byp_pkg::topo_e     topo,
   input  logic               sys_sel,
   output logic               need
);
   import byp_pkg::*;

   logic is_active;
   logic is_mem;

   assign is_mem    = (cls == CLS_MEM);
   assign is_active = (cls == CLS_MEM) || (cls == CLS_IO);

   always_comb begin
      unique case (topo)
         TOPO_SHARED:   need = is_active;
         TOPO_PERIPH:   need = is_mem;
         TOPO_RESIDENT: need = is_active && sys_sel;
         TOPO_COMBINED: need = is_mem && sys_sel;
         default:       need = 1'b0;
      endcase
   end

endmodule

// File: rtl/byp_yield_gate.sv
module byp_yield_gate (
   input  byp_pkg::stat_cls_e cls,
   input  logic               need,
   input  logic               peer_req,
   input  logic               any_urgent,
   input  logic               hp_req,
   input  logic               lock_n,
   input  logic               crq_lock_n,
   output logic               surrender
);
   import byp_pkg::*;

   logic halt_cause;
   logic peer_cause;
   logic cause_any;

   assign halt_cause = (cls == CLS_HALT);
   // A lower-priority request wins only when the bus is idle for us,
   // unless the strap promotes it to the urgency of a higher-priority one.
   assign peer_cause = peer_req && (any_urgent || !need) && crq_lock_n;
   assign cause_any  = halt_cause || hp_req || peer_cause;
   assign surrender  = lock_n && cause_any;

endmodule

// File: rtl/bus_yield_policy.sv
module bus_yield_policy #(
   parameter int unsigned STATUS_W  = 3,
   parameter int unsigned HALT_CODE = 3,
   parameter int unsigned IDLE_CODE = 7
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [STATUS_W-1:0] status,
   input  logic                strap_iob_n,
   input  logic                strap_resb,
   input  logic                strap_any,
   input  logic                sys_sel,
   input  logic                peer_req,
   input  logic                prio_in_n,
   input  logic                lock_n,
   input  logic                crq_lock_n,
   output logic                bus_need,
   output logic                surrender_ok
);
   import byp_pkg::*;

   stat_cls_e cls;
   topo_e     topo;
   logic      need_d;
   logic      surr_d;

   assign topo = straps_to_topo(strap_iob_n, strap_resb);

   byp_status_class #(
      .STATUS_W  (STATUS_W),
      .HALT_CODE (HALT_CODE),
      .IDLE_CODE (IDLE_CODE)
   ) u_class (
      .status (status),
      .cls    (cls)
   );

   byp_need_decode u_need (
      .cls     (cls),
      .topo    (topo),
      .sys_sel (sys_sel),
      .need    (need_d)
   );

   byp_yield_gate u_gate (
      .cls        (cls),
      .need       (need_d),
      .peer_req   (peer_req),
      .any_urgent (strap_any),
      .hp_req     (prio_in_n),
      .lock_n     (lock_n),
      .crq_lock_n (crq_lock_n),
      .surrender  (surr_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_need     <= 1'b0;
         surrender_ok <= 1'b0;
      end else begin
         bus_need     <= need_d;
         surrender_ok <= surr_d;
      end
   end

endmodule

// File: rtl/bus_yield_policy_chk.sv
module bus_yield_policy_chk #(
   parameter int unsigned STATUS_W  = 3,
   parameter int unsigned HALT_CODE = 3
) (
   input logic                clk,
   input logic                rst,
   input logic [STATUS_W-1:0] status,
   input logic                strap_iob_n,
   input logic                strap_resb,
   input logic                strap_any,
   input logic                peer_req,
   input logic                prio_in_n,
   input logic                lock_n,
   input logic                crq_lock_n,
   input logic                bus_need,
   input logic                surrender_ok
);
   logic rst_q = 1'b0;
   always_ff @(posedge clk) rst_q <= rst;

   always @(negedge clk) begin
      if (rst_q === 1'b1) begin
         // R1
         reset_clear_chk: assert (!bus_need && !surrender_ok);
      end
   end

   // R11
   lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
      !lock_n |=> !surrender_ok);

   // R8
   hp_yield_chk: assert property (@(posedge clk) disable iff (rst)
      lock_n && prio_in_n |=> surrender_ok);

   // R7
   halt_yield_chk: assert property (@(posedge clk) disable iff (rst)
      lock_n && (status == STATUS_W'(HALT_CODE)) |=> surrender_ok);

   // R13
   keep_bus_chk: assert property (@(posedge clk) disable iff (rst)
      !prio_in_n && !peer_req && (status != STATUS_W'(HALT_CODE)) |=> !surrender_ok);

   // R12
   crq_mask_chk: assert property (@(posedge clk) disable iff (rst)
      !crq_lock_n && !prio_in_n && (status != STATUS_W'(HALT_CODE)) |=> !surrender_ok);

   // R10
   any_urgent_chk: assert property (@(posedge clk) disable iff (rst)
      lock_n && crq_lock_n && strap_any && peer_req |=> surrender_ok);

   // R4
   periph_mem_only_chk: assert property (@(posedge clk) disable iff (rst)
      !strap_iob_n && !strap_resb && !status[STATUS_W-1] |=> !bus_need);

endmodule

bind bus_yield_policy bus_yield_policy_chk #(
   .STATUS_W  (STATUS_W),
   .HALT_CODE (HALT_CODE)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .status       (status),
   .strap_iob_n  (strap_iob_n),
   .strap_resb   (strap_resb),
   .strap_any    (strap_any),
   .peer_req     (peer_req),
   .prio_in_n    (prio_in_n),
   .lock_n       (lock_n),
   .crq_lock_n   (crq_lock_n),
   .bus_need     (bus_need),
   .surrender_ok (surrender_ok)
);

// File: tb/test_bus_yield_policy.sv
module test_bus_yield_policy;
   logic       clk = 1'b0;
   logic       rst;
   logic [2:0] status;
   logic       strap_iob_n, strap_resb, strap_any;
   logic       sys_sel, peer_req, prio_in_n, lock_n, crq_lock_n;
   logic       bus_need, surrender_ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bus_yield_policy i_bus_yield_policy (
      .clk(clk), .rst(rst), .status(status),
      .strap_iob_n(strap_iob_n), .strap_resb(strap_resb), .strap_any(strap_any),
      .sys_sel(sys_sel), .peer_req(peer_req), .prio_in_n(prio_in_n),
      .lock_n(lock_n), .crq_lock_n(crq_lock_n),
      .bus_need(bus_need), .surrender_ok(surrender_ok)
   );

   task automatic check(input logic got, input logic exp, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", what, got, exp);
      end
   endtask

   task automatic set_topo(input logic iob_n, input logic resb, input logic any);
      @(negedge clk);
      strap_iob_n = iob_n; strap_resb = resb; strap_any = any;
      peer_req = 0; prio_in_n = 0; lock_n = 1; crq_lock_n = 1; sys_sel = 1;
   endtask

   // Drive at a falling edge, let one rising edge capture, sample at the next falling edge.
   task automatic step(input logic [2:0] st, input logic sel, input logic cr,
                       input logic prn, input logic lk, input logic cql,
                       input logic en, input logic es, input string tag);
      @(negedge clk);
      status = st; sys_sel = sel; peer_req = cr; prio_in_n = prn;
      lock_n = lk; crq_lock_n = cql;
      @(posedge clk);
      @(negedge clk);
      check(bus_need, en, {tag, " bus_need"});
      check(surrender_ok, es, {tag, " surrender_ok"});
   endtask

   task automatic t_reset();
      @(negedge clk);
      strap_iob_n = 1; strap_resb = 0; strap_any = 1;
      status = 3'b100; sys_sel = 1; peer_req = 1; prio_in_n = 1;
      lock_n = 1; crq_lock_n = 1; rst = 1;
      @(posedge clk); @(negedge clk);
      check(bus_need, 1'b0, "R1 reset bus_need");
      check(surrender_ok, 1'b0, "R1 reset surrender_ok");
      rst = 0;
   endtask

   task automatic t_shared();
      set_topo(1, 0, 0);
      step(3'b000, 1, 0, 0, 1, 1, 1, 0, "R2 R3 shared io");
      step(3'b101, 1, 0, 0, 1, 1, 1, 0, "R2 R3 shared mem");
      step(3'b011, 1, 0, 0, 1, 1, 0, 1, "R7 shared halt");
      step(3'b111, 1, 0, 0, 1, 1, 0, 0, "R13 shared idle keeps bus");
      step(3'b111, 1, 1, 0, 1, 1, 0, 1, "R9 shared idle peer");
      step(3'b100, 1, 1, 0, 1, 1, 1, 0, "R9 shared mem peer held");
   endtask

   task automatic t_periph();
      set_topo(0, 0, 0);
      step(3'b001, 1, 0, 0, 1, 1, 0, 0, "R4 periph io");
      step(3'b110, 1, 0, 0, 1, 1, 1, 0, "R4 periph mem");
      step(3'b010, 1, 1, 0, 1, 1, 0, 1, "R9 periph io peer");
      step(3'b110, 1, 1, 0, 1, 1, 1, 0, "R9 periph mem peer held");
      step(3'b011, 1, 0, 0, 1, 1, 0, 1, "R7 periph halt");
   endtask

   task automatic t_resident();
      set_topo(1, 1, 0);
      step(3'b000, 1, 0, 0, 1, 1, 1, 0, "R5 resident io sel1");
      step(3'b000, 0, 0, 0, 1, 1, 0, 0, "R5 resident io sel0");
      step(3'b000, 0, 1, 0, 1, 1, 0, 1, "R9 resident sel0 peer");
      step(3'b101, 1, 1, 0, 1, 1, 1, 0, "R9 resident mem sel1 peer held");
      step(3'b111, 1, 0, 0, 1, 1, 0, 0, "R5 resident idle");
   endtask

   task automatic t_combined();
      set_topo(0, 1, 0);
      step(3'b100, 1, 0, 0, 1, 1, 1, 0, "R6 combined mem sel1");
      step(3'b001, 1, 0, 0, 1, 1, 0, 0, "R6 combined io sel1");
      step(3'b101, 0, 0, 0, 1, 1, 0, 0, "R6 combined mem sel0");
      step(3'b101, 0, 1, 0, 1, 1, 0, 1, "R9 combined sel0 peer");
      step(3'b001, 1, 1, 0, 1, 1, 0, 1, "R9 combined io peer");
      step(3'b110, 1, 1, 0, 1, 1, 1, 0, "R9 combined mem peer held");
      step(3'b011, 1, 0, 0, 1, 1, 0, 1, "R7 combined halt");
   endtask

   task automatic t_higher();
      set_topo(1, 0, 0);
      step(3'b100, 1, 0, 1, 1, 1, 1, 1, "R8 shared mem higher prio");
      set_topo(0, 1, 0);
      step(3'b110, 1, 0, 1, 1, 1, 1, 1, "R8 combined mem higher prio");
   endtask

   task automatic t_any();
      set_topo(1, 0, 1);
      step(3'b100, 1, 1, 0, 1, 1, 1, 1, "R10 any mem peer");
      step(3'b100, 1, 0, 0, 1, 1, 1, 0, "R10 any mem no peer");
      for (int i = 0; i < 3; i++) begin
         step(3'b101, 1, 1, 0, 1, 1, 1, 1, "R10 any transfer");
         step(3'b111, 1, 1, 0, 1, 1, 0, 1, "R10 any gap");
      end
   endtask

   task automatic t_lock();
      set_topo(1, 0, 1);
      step(3'b011, 1, 0, 0, 0, 1, 0, 0, "R11 lock halt");
      step(3'b100, 1, 0, 1, 0, 1, 1, 0, "R11 lock higher prio");
      step(3'b111, 1, 1, 0, 0, 1, 0, 0, "R11 lock idle peer");
   endtask

   task automatic t_crq_lock();
      set_topo(1, 0, 0);
      step(3'b111, 1, 1, 0, 1, 0, 0, 0, "R12 crq lock idle peer");
      set_topo(1, 0, 1);
      step(3'b100, 1, 1, 0, 1, 0, 1, 0, "R12 crq lock any peer");
      step(3'b011, 1, 1, 0, 1, 0, 0, 1, "R12 crq lock halt");
      step(3'b100, 1, 1, 1, 1, 0, 1, 1, "R12 crq lock higher prio");
   endtask

   task automatic t_latency();
      set_topo(1, 0, 0);
      step(3'b100, 1, 0, 0, 1, 1, 1, 0, "R14 latency setup");
      @(negedge clk);
      status = 3'b011;
      #2;
      check(bus_need, 1'b1, "R14 bus_need before edge");
      check(surrender_ok, 1'b0, "R14 surrender_ok before edge");
      @(posedge clk); @(negedge clk);
      check(bus_need, 1'b0, "R14 bus_need after edge");
      check(surrender_ok, 1'b1, "R14 surrender_ok after edge");
      @(negedge clk);
      rst = 1;
      @(posedge clk); @(negedge clk);
      check(surrender_ok, 1'b0, "R1 mid-run reset surrender_ok");
      rst = 0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      rst = 1; status = 3'b111; strap_iob_n = 1; strap_resb = 0; strap_any = 0;
      sys_sel = 1; peer_req = 0; prio_in_n = 0; lock_n = 1; crq_lock_n = 1;
      t_reset();
      t_shared();
      t_periph();
      t_resident();
      t_combined();
      t_higher();
      t_any();
      t_lock();
      t_crq_lock();
      t_latency();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         summary();
         $finish;
      end
   end
endmodule